// File: doc/BRIEF.md
# 8-bit Arithmetic and Logic Unit with Status Flags

This block is the data-path core of an 8-bit accumulator machine. On every cycle it takes an operation code, the value of the register under operation (accumulator or index register), and an 8-bit operand. From these it produces an 8-bit result and the next values of the four status flags: negative, overflow, zero and carry. The result and the next-flag vector are combinational. The flags themselves are held in a register inside the block. That register loads the next-flag vector on a rising clock edge only when the caller asserts the valid strobe. The current flags that feed the arithmetic (carry in, and the flags an operation leaves alone) come from that register.

Arithmetic is always plain binary. There is no decimal mode. Shifts, rotates, increment, decrement and pass-through act on the operand, so the caller routes either memory data or the accumulator into the operand input. Compare and bit test never change the register: for those two operations the result output simply repeats the register value. Codes 14 and 15 are unused and have no effect. Reset is asynchronous and active-low. Its release is synchronised to the clock over two stages.

Top module: `alu8_flags`

## Requirements
- R1: For every operation that produces a value (codes 0-4 and 7-13), the next Z flag is 1 exactly when the 8-bit result is zero, and the next N flag equals result bit 7. The flag vector is ordered {N,V,Z,C} on bits 3..0.
- R2: Add with carry (code 3) gives the result register+operand+C modulo 256. The new C is bit 8 of the 9-bit sum.
- R3: For add, V is the XOR of two carries: the carry into bit 7 (the sum of the low 7 bits of both inputs plus C, taken at bit 7) and the new C.
- R4: Subtract with carry (code 4) behaves as add (code 3) with the operand bitwise inverted. The incoming C acts as not-borrow, and V and C follow R2 and R3.
- R5: Compare (code 5) sets C when register >= operand as unsigned values. N and Z come from (register-operand) mod 256. V is unchanged and the result output equals the register.
- R6: Bit test (code 6) sets N to operand bit 7 and V to operand bit 6. Z is set when register AND operand is zero, C is unchanged, and the result output equals the register.
- R7: Shift left (code 7) moves operand bit 7 into C and shifts in 0. Shift right (code 8) moves operand bit 0 into C and shifts in 0.
- R8: Rotate left (code 9) shifts the old C into bit 0, and rotate right (code 10) shifts the old C into bit 7. In both cases the bit shifted out becomes the new C.
- R9: Increment (code 11) and decrement (code 12) of the operand wrap modulo 256 and leave C and V unchanged.
- R10: OR (code 0), AND (code 1), XOR (code 2) of register and operand, and pass-through of the operand (code 13), leave C and V unchanged.
- R11: The flag register clears to 0 on reset. It loads the next-flag vector on a rising edge only when op_valid is 1, and holds otherwise.
- R12: Codes 14 and 15 have no effect: the result equals the register value and the next-flag vector equals the current flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Strobe that lets the flag register load |
| op_code | input | 4 | Operation select |
| reg_val | input | 8 | Accumulator or index register value |
| operand | input | 8 | Operand byte |
| result | output | 8 | Combinational result |
| flags_nxt | output | 4 | Next flags {N,V,Z,C}, combinational |
| flags_q | output | 4 | Registered flags {N,V,Z,C} |

## Verification
The result and flags_nxt outputs are due in the same cycle the inputs are applied. The bench therefore drives on the falling edge and compares them a short delay later, well before the next rising edge. flags_q is due one rising edge after a strobed operation. It is compared at the following falling edge, just before new inputs are driven, against a bench model of the flag register that advances only on strobed operations. The checks cover random opcodes and operands drawn from a fixed seed, plus directed cases: the wrap points of add, subtract, increment and decrement, compare with equal and unequal values, and rotates with each carry value.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
  localparam int FLAG_N = 3;
  localparam int FLAG_V = 2;
  localparam int FLAG_Z = 1;
  localparam int FLAG_C = 0;
  localparam int FLAG_W = 4;

  typedef enum logic [3:0] {
    OP_OR   = 4'd0,
    OP_AND  = 4'd1,
    OP_XOR  = 4'd2,
    OP_ADC  = 4'd3,
    OP_SBC  = 4'd4,
    OP_CMP  = 4'd5,
    OP_BIT  = 4'd6,
    OP_SHL  = 4'd7,
    OP_SHR  = 4'd8,
    OP_ROL  = 4'd9,
    OP_ROR  = 4'd10,
    OP_INC  = 4'd11,
    OP_DEC  = 4'd12,
    OP_PASS = 4'd13,
    OP_NOP0 = 4'd14,
    OP_NOP1 = 4'd15
  } alu_op_e;
endpackage

// File: rtl/alu8_rst_sync.sv
module alu8_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/alu8_adder.sv
module alu8_adder #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout,
  output logic         ovf
);
  logic [W:0]   full;
  logic [W-1:0] low;

  always_comb begin
    full = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
    low  = {1'b0, a[W-2:0]} + {1'b0, b[W-2:0]} + {{(W-1){1'b0}}, cin};
    sum  = full[W-1:0];
    cout = full[W];
    // carry into the sign bit versus carry out of it
    ovf  = low[W-1] ^ full[W];
  end
endmodule

// File: rtl/alu8_shift.sv
module alu8_shift #(
  parameter int W = 8
) (
  input  logic [W-1:0] val,
  input  logic         cin,
  input  logic         to_right,
  input  logic         rotate,
  output logic [W-1:0] res,
  output logic         cout
);
  logic fill;

  always_comb begin
    fill = rotate & cin;
    if (to_right) begin
      res  = {fill, val[W-1:1]};
      cout = val[0];
    end else begin
      res  = {val[W-2:0], fill};
      cout = val[W-1];
    end
  end
endmodule

// File: rtl/alu8_flags.sv
module alu8_flags
  import alu8_pkg::*;
#(
  parameter int W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic [3:0]        op_code,
  input  logic [W-1:0]      reg_val,
  input  logic [W-1:0]      operand,
  output logic [W-1:0]      result,
  output logic [FLAG_W-1:0] flags_nxt,
  output logic [FLAG_W-1:0] flags_q
);
  alu_op_e op;
  logic    rst_sync_n;

  logic [W-1:0] add_b;
  logic         add_cin;
  logic [W-1:0] add_sum;
  logic         add_cout;
  logic         add_ovf;

  logic [W-1:0] sh_res;
  logic         sh_cout;
  logic         sh_right;
  logic         sh_rot;

  logic         nz_from_res;
  logic [FLAG_W-1:0] flags_d;

  assign op = alu_op_e'(op_code);

  alu8_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  // operand path of the adder: inverted for subtract and compare
  always_comb begin
    add_b   = operand;
    add_cin = flags_q[FLAG_C];
    if (op == OP_SBC) begin
      add_b = ~operand;
    end else if (op == OP_CMP) begin
      add_b   = ~operand;
      add_cin = 1'b1;
    end
  end

  alu8_adder #(.W(W)) u_add (
    .a    (reg_val),
    .b    (add_b),
    .cin  (add_cin),
    .sum  (add_sum),
    .cout (add_cout),
    .ovf  (add_ovf)
  );

  always_comb begin
    sh_right = (op == OP_SHR) || (op == OP_ROR);
    sh_rot   = (op == OP_ROL) || (op == OP_ROR);
  end

  alu8_shift #(.W(W)) u_sh (
    .val      (operand),
    .cin      (flags_q[FLAG_C]),
    .to_right (sh_right),
    .rotate   (sh_rot),
    .res      (sh_res),
    .cout     (sh_cout)
  );

  // result selection and next-flag computation
  always_comb begin
    result      = reg_val;
    flags_d     = flags_q;
    nz_from_res = 1'b1;
    unique case (op)
      OP_OR:   result = reg_val | operand;
      OP_AND:  result = reg_val & operand;
      OP_XOR:  result = reg_val ^ operand;
      OP_ADC, OP_SBC: begin
        result          = add_sum;
        flags_d[FLAG_C] = add_cout;
        flags_d[FLAG_V] = add_ovf;
      end
      OP_CMP: begin
        nz_from_res     = 1'b0;
        flags_d[FLAG_C] = add_cout;
        flags_d[FLAG_N] = add_sum[W-1];
        flags_d[FLAG_Z] = (add_sum == '0);
      end
      OP_BIT: begin
        nz_from_res     = 1'b0;
        flags_d[FLAG_N] = operand[W-1];
        flags_d[FLAG_V] = operand[W-2];
        flags_d[FLAG_Z] = ((reg_val & operand) == '0);
      end
      OP_SHL, OP_SHR, OP_ROL, OP_ROR: begin
        result          = sh_res;
        flags_d[FLAG_C] = sh_cout;
      end
      OP_INC:  result = operand + W'(1);
      OP_DEC:  result = operand - W'(1);
      OP_PASS: result = operand;
      default: nz_from_res = 1'b0;
    endcase
    if (nz_from_res) begin
      flags_d[FLAG_N] = result[W-1];
      flags_d[FLAG_Z] = (result == '0);
    end
    flags_nxt = flags_d;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)   flags_q <= '0;
    else if (op_valid) flags_q <= flags_d;
  end

  // R11: flags hold without the strobe
  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !op_valid |=> $stable(flags_q));

  // R11: a strobed operation lands in the register
  a_r11_load: assert property (@(posedge clk) disable iff (!rst_sync_n)
    op_valid |=> flags_q == $past(flags_nxt));

  // R9: increment and decrement keep carry and overflow
  a_r9_keep_cv: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (op_code == 4'd11 || op_code == 4'd12) |->
      (flags_nxt[FLAG_C] == flags_q[FLAG_C] && flags_nxt[FLAG_V] == flags_q[FLAG_V]));

  // R5, R6: compare and bit test never alter the register value
  a_r5_reg_kept: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (op_code == 4'd5 || op_code == 4'd6) |-> result == reg_val);

  // R6: bit test takes N and V from the operand
  a_r6_nv: assert property (@(posedge clk) disable iff (!rst_sync_n)
    op_code == 4'd6 |-> (flags_nxt[FLAG_N] == operand[W-1] && flags_nxt[FLAG_V] == operand[W-2]));

  // R1: zero flag agrees with the result for value-producing codes
  a_r1_zero: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (op_code <= 4'd4 || (op_code >= 4'd7 && op_code <= 4'd13)) |->
      flags_nxt[FLAG_Z] == (result == '0));

  // R12: unused codes change nothing
  a_r12_unused: assert property (@(posedge clk) disable iff (!rst_sync_n)
    op_code >= 4'd14 |-> (flags_nxt == flags_q && result == reg_val));
endmodule

// File: tb/sim_alu8_flags.sv
module sim_alu8_flags;
  logic       clk;
  logic       rst_n;
  logic       op_valid;
  logic [3:0] op_code;
  logic [7:0] reg_val;
  logic [7:0] operand;
  logic [7:0] result;
  logic [3:0] flags_nxt;
  logic [3:0] flags_q;

  int checks;
  int errors;
  bit done;
  logic [3:0] mflags;

  alu8_flags u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .op_valid  (op_valid),
    .op_code   (op_code),
    .reg_val   (reg_val),
    .operand   (operand),
    .result    (result),
    .flags_nxt (flags_nxt),
    .flags_q   (flags_q)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic string req_of(input logic [3:0] op);
    case (op)
      4'd3: return "R2/R3";
      4'd4: return "R4";
      4'd5: return "R5";
      4'd6: return "R6";
      4'd7, 4'd8: return "R7";
      4'd9, 4'd10: return "R8";
      4'd11, 4'd12: return "R9";
      4'd14, 4'd15: return "R12";
      default: return "R10";
    endcase
  endfunction

  // returns {result, N, V, Z, C}
  function automatic logic [11:0] model(input logic [3:0] op, input logic [7:0] r,
                                        input logic [7:0] o, input logic [3:0] f);
    logic [7:0] res;
    logic n, v, z, c;
    logic [8:0] s;
    logic [7:0] lo;
    logic [7:0] ob;
    logic [7:0] diff;
    n = f[3]; v = f[2]; z = f[1]; c = f[0];
    res = r;
    case (op)
      4'd0: res = r | o;
      4'd1: res = r & o;
      4'd2: res = r ^ o;
      4'd3, 4'd4: begin
        ob  = (op == 4'd4) ? ~o : o;
        s   = 9'(r) + 9'(ob) + 9'(c);
        lo  = 8'(r[6:0]) + 8'(ob[6:0]) + 8'(c);
        v   = lo[7] ^ s[8];
        c   = s[8];
        res = s[7:0];
      end
      4'd5: begin
        diff = r - o;
        c = (r >= o);
        n = diff[7];
        z = (diff == 8'd0);
      end
      4'd6: begin
        n = o[7];
        v = o[6];
        z = ((r & o) == 8'd0);
      end
      4'd7:  begin res = {o[6:0], 1'b0}; c = o[7]; end
      4'd8:  begin res = {1'b0, o[7:1]}; c = o[0]; end
      4'd9:  begin res = {o[6:0], c};    c = o[7]; end
      4'd10: begin res = {c, o[7:1]};    c = o[0]; end
      4'd11: res = o + 8'd1;
      4'd12: res = o - 8'd1;
      4'd13: res = o;
      default: ;
    endcase
    if (op <= 4'd4 || (op >= 4'd7 && op <= 4'd13)) begin
      n = res[7];
      z = (res == 8'd0);
    end
    return {res, n, v, z, c};
  endfunction

  task automatic check(input string req, input logic [11:0] act, input logic [11:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s op=%0d r=%h o=%h actual=%h expected=%h",
               req, op_code, reg_val, operand, act, exp);
    end
  endtask

  // one operation: drive at falling edge, check combinational outputs,
  // then check the flag register at the next falling edge
  task automatic do_op(input logic [3:0] op, input logic [7:0] r,
                       input logic [7:0] o, input logic vld);
    logic [11:0] exp;
    @(negedge clk);
    op_code = op; reg_val = r; operand = o; op_valid = vld;
    #1;
    exp = model(op, r, o, mflags);
    check(req_of(op), {result, flags_nxt}, exp);
    // R1: N and Z against the result for value-producing codes
    if (op <= 4'd4 || (op >= 4'd7 && op <= 4'd13))
      check("R1", {8'd0, flags_nxt[3], 2'b0, flags_nxt[1]},
            {8'd0, result[7], 2'b0, (result == 8'd0)});
    if (vld) mflags = exp[3:0];
    @(negedge clk);
    op_valid = 1'b0;
    check("R11", {8'd0, flags_q}, {8'd0, mflags});
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int seed;
    checks = 0; errors = 0; done = 0;
    mflags = 4'h0;
    op_valid = 1'b0; op_code = 4'd13; reg_val = 8'h00; operand = 8'h00;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R11: reset state
    check("R11", {8'd0, flags_q}, 12'h000);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);

    // directed corner cases
    do_op(4'd3, 8'h7F, 8'h01, 1'b1);  // R3 positive overflow
    do_op(4'd3, 8'hFF, 8'h01, 1'b1);  // R2 carry out, zero
    do_op(4'd3, 8'h10, 8'h20, 1'b1);  // R2 carry in used
    do_op(4'd4, 8'h80, 8'h01, 1'b1);  // R4 negative overflow
    do_op(4'd5, 8'h42, 8'h42, 1'b1);  // R5 equal
    do_op(4'd5, 8'h10, 8'h20, 1'b1);  // R5 less
    do_op(4'd4, 8'h00, 8'h01, 1'b1);  // R4 borrow in
    do_op(4'd6, 8'h0F, 8'hC0, 1'b1);  // R6 N,V set, Z set
    do_op(4'd6, 8'hFF, 8'h01, 1'b1);  // R6 clears N,V
    do_op(4'd5, 8'hFF, 8'h00, 1'b1);  // set C
    do_op(4'd9, 8'h00, 8'h80, 1'b1);  // R8 rotate in 1, out 1
    do_op(4'd10, 8'h00, 8'h01, 1'b1); // R8
    do_op(4'd7, 8'h00, 8'h80, 1'b1);  // R7 result zero, C=1
    do_op(4'd8, 8'h00, 8'h01, 1'b1);  // R7
    do_op(4'd11, 8'h00, 8'hFF, 1'b1); // R9 wrap up
    do_op(4'd12, 8'h00, 8'h00, 1'b1); // R9 wrap down
    do_op(4'd13, 8'h00, 8'h00, 1'b1); // R10 pass zero
    do_op(4'd14, 8'h5A, 8'hA5, 1'b1); // R12
    do_op(4'd15, 8'h00, 8'hFF, 1'b1); // R12
    do_op(4'd3, 8'h7F, 8'h7F, 1'b0);  // R11 no strobe, flags hold

    seed = 1234;
    void'($urandom(seed));
    for (int i = 0; i < 600; i++) begin
      logic [3:0] op;
      logic [7:0] r, o;
      logic v;
      op = 4'($urandom_range(0, 15));
      r  = 8'($urandom);
      o  = 8'($urandom);
      v  = ($urandom_range(0, 4) != 0);
      do_op(op, r, o, v);
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule